// File: doc/BRIEF.md
# Serial DAC Input Controller

This block is the digital front end of a two-channel 12-bit digital-to-analog converter. A host sends 16-bit command words over a three-wire serial link: an active-low select, a serial clock and a data line. The three inputs are synchronised into the system clock domain. Data bits are taken on falling serial-clock edges, most significant bit first, while select is low. The block keeps two 12-bit output codes and a 12-bit holding buffer, and it raises a one-cycle update strobe whenever an output code is written.

Two framing modes exist, and the `auto_mode` input picks one. The mode is sampled when a frame opens. In counting mode the controller counts serial clocks from the falling edge of select. On the sixteenth bit it commits the word on its own and then enters a locked state, in which further clocks and data are ignored until select rises. In legacy mode there is no internal sequencing. Bits keep shifting until select rises, and on that rising edge the last sixteen bits received are committed.

The controller has three states. `ST_IDLE` waits for select to fall and moves to `ST_SHIFT`. In `ST_SHIFT`, a rising select returns to `ST_IDLE`, and in legacy mode this also commits a full word. In counting mode the sixteenth bit moves the controller to `ST_LOCK`. `ST_LOCK` returns to `ST_IDLE` when select rises.

Top module: `serial_dac_ctrl`

## Requirements
- R1: Reset sets both output codes and the holding buffer to zero and keeps the update strobe low.
- R2: Bits are sampled on falling edges of `sclk` while `cs_n` is low, most significant bit first. Frame bit 15 is the first bit sent.
- R3: In counting mode (`auto_mode`=1 when `cs_n` falls), the word is committed after the sixteenth sampled bit, while `cs_n` is still low.
- R4: In counting mode, clocks and data that arrive after the commit leave every register unchanged until `cs_n` rises.
- R5: In legacy mode (`auto_mode`=0), nothing is committed while `cs_n` stays low. On the rising edge of `cs_n`, the last 16 bits received are committed, provided at least 16 were received.
- R6: A frame that ends with fewer than 16 bits changes no register and gives no strobe, in either mode.
- R7: Word fields: bit 14 set writes bits 11:0 to the holding buffer only. With bit 14 clear, bit 15 set writes channel A and bit 15 clear writes channel B. Bits 13:12 have no effect.
- R8: A direct write to channel A loads the current holding-buffer contents into channel B in the same cycle.
- R9: `upd` is high for exactly one clock per direct write, in the cycle the new codes first appear. It stays low for holding-buffer writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_mode | input | 1 | 1 = counting mode, 0 = legacy mode; sampled at frame start |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock; data taken on its falling edge |
| sdi | input | 1 | Serial data in |
| code_a | output | 12 | Channel A output code |
| code_b | output | 12 | Channel B output code |
| upd | output | 1 | One-cycle strobe when an output code is written |

## Verification
The assertions check the following on every cycle:
- A counting-mode commit happens only on the sixteenth bit, before select rises.
- A legacy commit happens only on a select rise after a full word.
- Nothing is committed in the locked state or on a short frame.
- A channel A write carries the holding buffer into channel B.
- The strobe is a single pulse that never follows a buffer write.

Only the bench scenarios can show the rest, because these properties depend on whole frames:
- Bit order.
- That counting mode keeps the first sixteen bits of an over-long frame while legacy mode keeps the last sixteen.
- That the reserved bits are ignored.
- That the output codes match a reference model across random frames of mixed lengths and modes.

// File: rtl/dacsif_pkg.sv
package dacsif_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LOCK  = 2'd2
    } dacsif_state_t;

endpackage

// File: rtl/dacsif_sync.sv
module dacsif_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) pipe[s] <= RST_VAL;
        end else begin
            pipe[0] <= din;
            for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
        end
    end

    assign dout = pipe[STAGES-1];

endmodule

// File: rtl/dacsif_fsm.sv
module dacsif_fsm
    import dacsif_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int CTRL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_in,
    input  logic              cs_n_s,
    input  logic              sclk_s,
    input  logic              sdi_s,
    output logic              commit,
    output logic              cmd_sel_a,
    output logic              cmd_to_buf,
    output logic [CODE_W-1:0] cmd_code
);

    localparam int WORD_W = CODE_W + CTRL_W;
    localparam int CNT_W  = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

    dacsif_state_t state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] sh_q;
    logic              mode_q;
    logic              cs_d, sclk_d;
    logic              cs_fall, cs_rise, sclk_fall;

    assign cs_fall   =  cs_d & ~cs_n_s;
    assign cs_rise   = ~cs_d &  cs_n_s;
    assign sclk_fall =  sclk_d & ~sclk_s;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cs_fall) state_d = ST_SHIFT;
            ST_SHIFT: begin
                if (cs_rise) state_d = ST_IDLE;
                else if (sclk_fall && mode_q && cnt_q == CNT_LAST) state_d = ST_LOCK;
            end
            ST_LOCK:  if (cs_rise) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // datapath: edge history, bit counter, shift register, mode latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_d   <= 1'b1;
            sclk_d <= 1'b0;
            cnt_q  <= '0;
            sh_q   <= '0;
            mode_q <= 1'b0;
        end else begin
            cs_d   <= cs_n_s;
            sclk_d <= sclk_s;
            if (state_q == ST_IDLE && cs_fall) begin
                cnt_q  <= '0;
                mode_q <= mode_in;
            end else if (state_q == ST_SHIFT && !cs_rise && sclk_fall) begin
                sh_q <= {sh_q[WORD_W-2:0], sdi_s};
                if (cnt_q != CNT_FULL) cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // output decode: commit pulse and command fields
    always_comb begin
        commit     = 1'b0;
        cmd_sel_a  = sh_q[WORD_W-1];
        cmd_to_buf = sh_q[WORD_W-2];
        cmd_code   = sh_q[CODE_W-1:0];
        if (state_q == ST_SHIFT) begin
            if (mode_q) begin
                commit     = sclk_fall && !cs_rise && cnt_q == CNT_LAST;
                cmd_sel_a  = sh_q[WORD_W-2];
                cmd_to_buf = sh_q[WORD_W-3];
                cmd_code   = {sh_q[CODE_W-2:0], sdi_s};
            end else begin
                commit     = cs_rise && cnt_q == CNT_FULL;
            end
        end
    end

    p_auto_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && mode_q) |-> (!cs_rise && sclk_fall && cnt_q == CNT_LAST));

    p_lock_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCK) |-> !commit);

    p_legacy_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !mode_q) |-> cs_rise);

    p_short_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q < CNT_LAST) |-> !commit);

endmodule

// File: rtl/dacsif_regs.sv
module dacsif_regs #(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic              cmd_sel_a,
    input  logic              cmd_to_buf,
    input  logic [CODE_W-1:0] cmd_code,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b,
    output logic              upd
);

    logic [CODE_W-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_a <= '0;
            code_b <= '0;
            hold_q <= '0;
            upd    <= 1'b0;
        end else begin
            upd <= 1'b0;
            if (commit) begin
                if (cmd_to_buf) begin
                    hold_q <= cmd_code;
                end else if (cmd_sel_a) begin
                    code_a <= cmd_code;
                    code_b <= hold_q;
                    upd    <= 1'b1;
                end else begin
                    code_b <= cmd_code;
                    upd    <= 1'b1;
                end
            end
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (code_a == '0 && code_b == '0 && hold_q == '0 && !upd));

    p_quiet_regs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(code_a) && $stable(code_b) && $stable(hold_q)));

    p_pair_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && cmd_sel_a && !cmd_to_buf) |=> (code_b == $past(hold_q)));

    p_buf_no_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && cmd_to_buf) |=> !upd);

    p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> !upd);

endmodule

// File: rtl/serial_dac_ctrl.sv
module serial_dac_ctrl #(
    parameter int CODE_W      = 12,
    parameter int CTRL_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              auto_mode,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b,
    output logic              upd
);

    logic [2:0]        pins_s;
    logic              commit, cmd_sel_a, cmd_to_buf;
    logic [CODE_W-1:0] cmd_code;

    dacsif_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b001)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({sdi, sclk, cs_n}),
        .dout  (pins_s)
    );

    dacsif_fsm #(
        .CODE_W (CODE_W),
        .CTRL_W (CTRL_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_in    (auto_mode),
        .cs_n_s     (pins_s[0]),
        .sclk_s     (pins_s[1]),
        .sdi_s      (pins_s[2]),
        .commit     (commit),
        .cmd_sel_a  (cmd_sel_a),
        .cmd_to_buf (cmd_to_buf),
        .cmd_code   (cmd_code)
    );

    dacsif_regs #(
        .CODE_W (CODE_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .cmd_sel_a  (cmd_sel_a),
        .cmd_to_buf (cmd_to_buf),
        .cmd_code   (cmd_code),
        .code_a     (code_a),
        .code_b     (code_b),
        .upd        (upd)
    );

endmodule

// File: tb/serial_dac_ctrl_bench.sv
module serial_dac_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        auto_mode = 1'b1;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic [11:0] code_a, code_b;
    logic        upd;

    int total = 0;
    int bad = 0;
    int upd_seen = 0;
    bit finished = 0;

    logic [11:0] exp_a = '0, exp_b = '0, exp_h = '0;
    int          exp_upd = 0;

    always #2 clk = ~clk;

    serial_dac_ctrl u_serial_dac_ctrl (
        .clk(clk), .rst_n(rst_n), .auto_mode(auto_mode), .cs_n(cs_n),
        .sclk(sclk), .sdi(sdi), .code_a(code_a), .code_b(code_b), .upd(upd)
    );

    always @(negedge clk) if (upd) upd_seen++;

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference model of a committed word (R7, R8, R9)
    function automatic void model_apply(input logic [15:0] w);
        if (w[14]) exp_h = w[11:0];
        else if (w[15]) begin exp_b = exp_h; exp_a = w[11:0]; exp_upd++; end
        else begin exp_b = w[11:0]; exp_upd++; end
    endfunction

    function automatic void model_frame(input logic m, input logic [31:0] pat, input int n);
        if (n < 16) return;
        if (m) model_apply(16'(pat >> (n - 16)));
        else   model_apply(pat[15:0]);
    endfunction

    task automatic send(input logic m, input logic [31:0] pat, input int n, input bit rel);
        auto_mode = m;
        cs_n = 1'b0;
        wait_clk(5);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = pat[i];
            wait_clk(3);
            sclk = 1'b1;
            wait_clk(4);
            sclk = 1'b0;
            wait_clk(3);
        end
        wait_clk(8);
        if (rel) begin
            cs_n = 1'b1;
            wait_clk(8);
        end
    endtask

    task automatic check_all(input string req);
        check({req, " code_a"}, int'(code_a), int'(exp_a));
        check({req, " code_b"}, int'(code_b), int'(exp_b));
        check({req, " upd count"}, upd_seen, exp_upd);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        wait_clk(5);
        check("R1 reset code_a", int'(code_a), 0);
        check("R1 reset code_b", int'(code_b), 0);
        check("R1 reset upd", int'(upd), 0);
        rst_n = 1'b1;
        wait_clk(4);

        // R2/R7: counting mode, direct write to B, MSB first
        send(1'b1, 32'h0ABC, 16, 1'b1); model_apply(16'h0ABC);
        check_all("R2 R7 write B");

        // R7/R9: buffer write with reserved bits set, no output change
        send(1'b1, 32'h7123, 16, 1'b1); model_apply(16'h7123);
        check_all("R7 R9 buffer write");

        // R8: A write pulls buffer into B
        send(1'b1, 32'h8456, 16, 1'b1); model_apply(16'h8456);
        check_all("R8 A write with B pairing");

        // R3: committed while cs_n still low; R4: extra clocks ignored
        send(1'b1, 32'h0321, 16, 1'b0); model_apply(16'h0321);
        check_all("R3 commit before cs rise");
        for (int i = 0; i < 6; i++) begin
            sdi = 1'b1; wait_clk(3); sclk = 1'b1; wait_clk(4); sclk = 1'b0; wait_clk(3);
        end
        wait_clk(6);
        check_all("R4 lock before release");
        cs_n = 1'b1; wait_clk(8);
        check_all("R4 lock after release");

        // R6: short frames, both modes
        send(1'b1, 32'h0FFF, 10, 1'b1);
        check_all("R6 short counting frame");
        send(1'b0, 32'h8FFF, 15, 1'b1);
        check_all("R6 short legacy frame");

        // R5: legacy holds until cs rises
        send(1'b0, 32'h0777, 16, 1'b0);
        check_all("R5 legacy no commit while low");
        cs_n = 1'b1; wait_clk(8); model_apply(16'h0777);
        check_all("R5 legacy commit on rise");

        // R5: long legacy frame keeps last 16 bits; R3: long counting keeps first 16
        send(1'b0, 32'h000A_8999, 20, 1'b1); model_frame(1'b0, 32'h000A_8999, 20);
        check_all("R5 legacy last 16 bits");
        send(1'b1, 32'h0008_5550, 20, 1'b1); model_frame(1'b1, 32'h0008_5550, 20);
        check_all("R3 counting first 16 bits");

        // randomized frames
        for (int k = 0; k < 40; k++) begin
            logic        m;
            logic [31:0] pat;
            int          n;
            m   = 1'($urandom_range(0, 1));
            pat = $urandom();
            n   = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 20)) : 16;
            send(m, pat, n, 1'b1);
            model_frame(m, pat, n);
            check_all("R2 R7 random frame");
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule